// File: doc/BRIEF.md
# Redundant Reference Clock Switchover Controller

This block watches two reference clocks and decides which of them feeds the reference input of a downstream PLL. One input, called the reference input (`ref_a`), is the only one that may serve as primary for automatic switching. The other input (`ref_b`) may also be made primary, but automatic switching is then unavailable. Both references are sampled by a faster free-running system clock. Each reference passes through a two-flop synchronizer and an edge detector, which give one activity pulse per rising edge. The system clock must run at least four times faster than either reference.

A two-bit mode field sets the switching policy. In manual mode the select pin chooses the source directly. In automatic mode the block moves to the secondary source when the primary goes quiet. It then either stays there until the select pin is toggled (non-revertive) or returns by itself once the primary is healthy again (revertive). The block produces three outputs: the source select, a flag that the chosen input is missing, and a lock-loss flag. Every change of source forces the lock-loss flag high for a fixed number of edges of the new clock. The analog PLL, the clock mux and the phase comparison are outside the block; it only takes a lock indication from the PLL.

Top module: `refclk_switchover`

## Requirements
- R1: While `rst_n` is low, at each clock edge the block selects the primary (`use_b` equals `prim_b`) and clears `clk_lost`. In that state `lock_lost` is high whenever `pll_lock` is low.
- R2: `prim_b`=0 makes `ref_a` primary and `ref_b` secondary, and `prim_b`=1 swaps the two. `use_b`=1 means `ref_b` is routed to the PLL.
- R3: In manual mode (`mode` = 00 or 01), the synchronized level of `sel_pin` alone picks the source: 0 selects primary and 1 selects secondary, so `use_b` = `sel_pin` XOR `prim_b`.
- R4: In automatic mode (`mode[1]`=1) with `prim_b`=0, the block moves to secondary after MISS_EDGES (2) secondary rising edges with no primary rising edge between them. It does not switch while the primary keeps toggling at a rate at least equal to the secondary.
- R5: Non-revertive mode (`mode`=10): once on secondary, the block stays there even if the primary recovers or the secondary fails. Only a change of level on `sel_pin` brings it back to primary.
- R6: Revertive mode (`mode`=11): once on secondary, the block returns to primary after RECOVER_EDGES (2) back-to-back secondary periods that each contain a primary rising edge. It stays on secondary while the primary is dead.
- R7: On every change of `use_b`, whatever its cause, `lock_lost` goes high in the same cycle. It stays high until HOLD_EDGES (2) rising edges of the newly selected clock have been seen, even while `pll_lock` is high.
- R8: Outside that forced window, `lock_lost` is high exactly when `pll_lock` is low.
- R9: `clk_lost` is high when the selected input has shown no rising edge for TIMEOUT_CYCLES (64) system clocks, or when both inputs are idle that long. A quiet unselected input alone leaves it low.
- R10: With `prim_b`=1, both automatic modes act as manual mode. The select pin decides, and a dead primary causes no switch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | free-running system clock, at least 4x each reference |
| rst_n | input | 1 | synchronous active-low reset |
| ref_a | input | 1 | reference input, the only one that allows automatic switching as primary |
| ref_b | input | 1 | alternate reference input |
| prim_b | input | 1 | 1 makes ref_b primary, 0 makes ref_a primary |
| mode | input | 2 | 0x manual, 10 automatic non-revertive, 11 automatic revertive |
| sel_pin | input | 1 | asynchronous source-select / return-request pin |
| pll_lock | input | 1 | lock indication from the PLL |
| use_b | output | 1 | 1 routes ref_b to the PLL, 0 routes ref_a |
| clk_lost | output | 1 | selected input (or both inputs) missing |
| lock_lost | output | 1 | forced switchover window or PLL not locked |

## Verification
The bench changes the select pin on a rising edge of the secondary clock. That edge is still inside the synchronizer when the switch happens. A design that counted this stale edge, or that counted edges of the old clock, would drop `lock_lost` after one new edge instead of two. In non-revertive mode the bench revives the primary and kills the secondary while the block sits on secondary; a design that reverts on its own would flip `use_b`. In revertive mode the bench keeps the primary dead for a long spell before reviving it, which catches an early return. The bench also stops only the unselected input, and then both inputs, to show that `clk_lost` follows the selected source and not just any quiet input.

// File: rtl/refclk_switchover.sv
`timescale 1ns/1ps
module refclk_switchover #(
  parameter int HOLD_EDGES     = 2,
  parameter int MISS_EDGES     = 2,
  parameter int RECOVER_EDGES  = 2,
  parameter int TIMEOUT_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_a,
  input  logic       ref_b,
  input  logic       prim_b,
  input  logic [1:0] mode,
  input  logic       sel_pin,
  input  logic       pll_lock,
  output logic       use_b,
  output logic       clk_lost,
  output logic       lock_lost
);
  localparam int HW = $clog2(HOLD_EDGES + 1);
  localparam int EMAX = (MISS_EDGES > RECOVER_EDGES) ? MISS_EDGES : RECOVER_EDGES;
  localparam int EW = $clog2(EMAX + 1);
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);

  logic [1:0] refs, act, idle;
  assign refs = {ref_b, ref_a};

  for (genvar g = 0; g < 2; g++) begin : g_in
    logic [2:0]    sh;
    logic [TW-1:0] quiet;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sh    <= '0;
        quiet <= '0;
      end else begin
        sh <= {sh[1:0], refs[g]};
        if (act[g])                           quiet <= '0;
        else if (quiet != TW'(TIMEOUT_CYCLES)) quiet <= quiet + 1'b1;
      end
    end
    assign act[g]  = sh[1] & ~sh[2];
    assign idle[g] = (quiet == TW'(TIMEOUT_CYCLES));
  end

  logic sel_s1, sel_s, sel_d;
  always_ff @(posedge clk) begin
    if (!rst_n) {sel_s1, sel_s, sel_d} <= '0;
    else        {sel_s1, sel_s, sel_d} <= {sel_pin, sel_s1, sel_s};
  end

  logic prim_act, sec_act, prim_seen;
  logic [EW-1:0] miss, rec;
  assign prim_act = act[prim_b];
  assign sec_act  = act[~prim_b];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      miss      <= '0;
      rec       <= '0;
      prim_seen <= 1'b0;
    end else begin
      if (prim_act)                         miss <= '0;
      else if (sec_act && miss != EW'(EMAX)) miss <= miss + 1'b1;
      if (sec_act) begin
        prim_seen <= 1'b0;
        if (!(prim_seen || prim_act)) rec <= '0;
        else if (rec != EW'(EMAX))    rec <= rec + 1'b1;
      end else if (prim_act) begin
        prim_seen <= 1'b1;
      end
    end
  end

  logic auto_ok, prim_dead, prim_back, on_sec, nxt_sec, nxt_use, sw;
  assign auto_ok   = mode[1] & ~prim_b;
  assign prim_dead = (miss >= EW'(MISS_EDGES));
  assign prim_back = (rec >= EW'(RECOVER_EDGES));

  always_comb begin
    if (!auto_ok)     nxt_sec = sel_s;
    else if (!on_sec) nxt_sec = prim_dead;
    else if (mode[0]) nxt_sec = ~prim_back;
    else              nxt_sec = ~(sel_s ^ sel_d);
  end
  assign nxt_use = nxt_sec ^ prim_b;
  assign sw      = (nxt_use != use_b);

  logic [HW-1:0] hold;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      on_sec <= 1'b0;
      use_b  <= prim_b;
      hold   <= '0;
    end else begin
      on_sec <= nxt_sec;
      use_b  <= nxt_use;
      if (sw)                        hold <= HW'(HOLD_EDGES);
      else if (hold != 0 && act[use_b]) hold <= hold - 1'b1;
    end
  end

  assign lock_lost = (hold != '0) | ~pll_lock;
  assign clk_lost  = idle[use_b] | (&idle);
endmodule

// File: rtl/refclk_switchover_chk.sv
`timescale 1ns/1ps
module refclk_switchover_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       prim_b,
  input logic       use_b,
  input logic       lock_lost,
  input logic       pll_lock,
  input logic       sel_s
);
  assert_manual_follows_pin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(!mode[1] || prim_b) && $past(prim_b) == prim_b)
      |-> use_b == ($past(sel_s) ^ prim_b));

  assert_nonrev_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode) == 2'b10 && !$past(prim_b) && $past(use_b)
     && $past(sel_s) == $past(sel_s, 2))
      |-> use_b);

  assert_switch_forces_loss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(use_b) |-> lock_lost);

  assert_release_needs_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_lost) |-> pll_lock);
endmodule

bind refclk_switchover refclk_switchover_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .prim_b(prim_b), .use_b(use_b),
  .lock_lost(lock_lost), .pll_lock(pll_lock), .sel_s(sel_s)
);

// File: tb/tb_refclk_switchover.sv
`timescale 1ns/1ps
module tb_refclk_switchover;
  logic clk = 0, rst_n = 0, ref_a = 0, ref_b = 0, prim_b = 0, sel_pin = 0, pll_lock = 0;
  logic [1:0] mode = 2'b00;
  logic use_b, clk_lost, lock_lost;
  int checks = 0, fails = 0, ha = 20, hb = 24;
  bit en_a = 1, en_b = 1, done = 0;

  refclk_switchover dut (.clk(clk), .rst_n(rst_n), .ref_a(ref_a), .ref_b(ref_b),
    .prim_b(prim_b), .mode(mode), .sel_pin(sel_pin), .pll_lock(pll_lock),
    .use_b(use_b), .clk_lost(clk_lost), .lock_lost(lock_lost));

  initial forever #2 clk = ~clk;
  initial begin #1; forever begin #(ha); ref_a = en_a ? ~ref_a : 1'b0; end end
  initial begin #1; forever begin #(hb); ref_b = en_b ? ~ref_b : 1'b0; end end

  function automatic bit exp_manual(bit sel, bit pb);
    return sel ^ pb;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_switch(input int maxc);
    logic start;
    start = use_b;
    for (int i = 0; i < maxc && use_b == start; i++) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    if (!done) $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R1/R2: reset state for both primary choices
    prim_b = 1; cyc(3);
    chk("R1 use_b in reset (prim_b=1)", use_b, 1);
    chk("R1 lock_lost in reset", lock_lost, 1);
    chk("R1 clk_lost in reset", clk_lost, 0);
    prim_b = 0; cyc(3);
    chk("R2 use_b in reset (prim_b=0)", use_b, 0);
    rst_n = 1; pll_lock = 1; cyc(50);
    chk("R8 lock_lost with lock", lock_lost, 0);
    chk("R9 clk_lost both running", clk_lost, 0);
    pll_lock = 0; cyc(2);
    chk("R8 lock_lost without lock", lock_lost, 1);
    pll_lock = 1;

    // R3/R10: random manual configurations
    void'($urandom(32'h5eed));
    for (int i = 0; i < 24; i++) begin
      ha = 16 + 4 * $urandom_range(0, 4);
      hb = 16 + 4 * $urandom_range(0, 4);
      prim_b = $urandom_range(0, 1);
      mode = prim_b ? 2'($urandom_range(0, 3)) : 2'($urandom_range(0, 1));
      sel_pin = $urandom_range(0, 1);
      cyc(70);
      chk(prim_b && mode[1] ? "R10 pin decides with prim_b=1" : "R3 manual pin level",
          use_b, exp_manual(sel_pin, prim_b));
      chk("R7 window ends after new edges", lock_lost, 0);
    end

    // R10: auto mode, primary ref_b dies, no switch
    prim_b = 1; mode = 2'b11; sel_pin = 0; cyc(60);
    en_b = 0; cyc(120);
    chk("R10 no auto switch with prim_b=1", use_b, 1);
    en_b = 1; cyc(60);

    // R7: switch on a secondary edge, count edges of the new clock
    prim_b = 0; mode = 2'b00; sel_pin = 0; ha = 20; hb = 24; cyc(80);
    @(posedge ref_b); sel_pin = 1;
    cyc(3);
    chk("R7 use_b after manual switch", use_b, 1);
    chk("R7 lock_lost at switch", lock_lost, 1);
    @(posedge ref_b); cyc(4);
    chk("R7 still forced after one new edge", lock_lost, 1);
    @(posedge ref_b); cyc(4);
    chk("R7 released after two new edges", lock_lost, 0);
    pll_lock = 0; @(posedge ref_b); sel_pin = 0;
    repeat (3) @(posedge ref_a); cyc(4);
    chk("R8 held by missing lock after window", lock_lost, 1);
    pll_lock = 1; cyc(2);
    chk("R8 release on lock", lock_lost, 0);

    // R9: selected/unselected/both idle
    sel_pin = 1; cyc(60);
    en_b = 0; cyc(90);
    chk("R9 selected input idle", clk_lost, 1);
    en_b = 1; cyc(40);
    chk("R9 selected input back", clk_lost, 0);
    en_a = 0; cyc(90);
    chk("R9 unselected idle only", clk_lost, 0);
    en_b = 0; cyc(90);
    chk("R9 both idle", clk_lost, 1);
    en_a = 1; en_b = 1; sel_pin = 0; cyc(60);

    // R4/R5: non-revertive, primary at least as fast as secondary
    ha = 16 + 4 * $urandom_range(0, 2); hb = ha + 4 * $urandom_range(0, 2);
    mode = 2'b10; cyc(100);
    chk("R4 no switch while primary runs", use_b, 0);
    en_a = 0; wait_switch(150);
    chk("R4 auto switch to secondary", use_b, 1);
    chk("R7 lock_lost at auto switch", lock_lost, 1);
    en_a = 1; cyc(120);
    chk("R5 stays on secondary, primary back", use_b, 1);
    en_b = 0; cyc(120);
    chk("R5 stays on secondary, secondary dead", use_b, 1);
    en_b = 1; cyc(40);
    sel_pin = 1; cyc(8);
    chk("R5 pin toggle restores primary", use_b, 0);
    cyc(60);
    chk("R5 no switch after return", use_b, 0);

    // R6: revertive
    sel_pin = 0; mode = 2'b11; cyc(40);
    en_a = 0; wait_switch(150);
    chk("R6 switch to secondary", use_b, 1);
    cyc(150);
    chk("R6 stays while primary dead", use_b, 1);
    en_a = 1; wait_switch(150);
    chk("R6 returns to primary", use_b, 0);
    chk("R7 lock_lost on return", lock_lost, 1);
    cyc(80);
    chk("R6 remains on primary", use_b, 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule